// File: doc/BRIEF.md
# Palette Host Register Port

This block is the processor-facing side of a colour palette unit. A host reaches it over an 8-bit data path with a 3-bit register select and active-low read and write strobes. The strobes are sampled by the block clock. Through this port the host sets a pixel mask byte and a command byte, and it loads or reads back a 256-entry palette and a 16-slot overlay table. Every entry in both tables is 24 bits wide. The command byte appears directly on a set of general-purpose control pins. The on-chip bus is split into `dataIn`, `dataOut` and an output enable `dataOe`, so a pad ring or a bus bridge can join them into one bidirectional bus.

A full colour entry moves as three byte transfers through three holding registers: red, then green, then blue. One address register serves both tables. It steps forward after each complete entry, so the host can stream consecutive entries without rewriting the address. If the read and write strobes are low at the same time, the block raises an error flag and drops the access.

Top module: `palHostPort`

## Requirements
- R1: The register select is captured at the clock edge where the write strobe is first seen low. The data byte is taken at the edge where the strobe is first seen high again. The target register updates at that second edge. Select codes: 0 = palette write address, 1 = palette data, 2 = pixel mask, 3 = palette read address, 4 = overlay write address, 5 = overlay data, 6 = command, 7 = overlay read address.
- R2: The command register drives `ctrlOut` directly. It changes only when a write to select 6 completes.
- R3: The pixel mask register can be written and read back through select 2.
- R4: Palette data writes fill red, green and blue in that order. The third byte stores {red,green,blue} (red in bits 23:16) at the current address, increments the address by one and returns to red. Writing either address resets the byte order to red.
- R5: Writing a read address loads the holding registers from that palette entry. Data reads then return red, green and blue. After the blue read completes, the address increments, wrapping from 255 to 0, and the next entry is loaded.
- R6: Overlay accesses use the low 4 address bits. Slots 1 to 15 store and return entries. Data written to slot 0 is discarded, and slot 0 always reads as zero. The address and byte-order sequencing is the same as for the palette.
- R7: If both strobes are seen low in the same cycle, `protoErr` goes high from the next cycle and stays high until both strobes are seen high together. An access that overlaps this condition changes no register.
- R8: Reads of selects 0, 3, 4 and 7 return the current address register.
- R9: `dataOe` is high only while a valid read is active, from the edge where the read strobe is first seen low until the edge where it is seen high. At all other times `dataOut` is zero.
- R10: After reset, every register and table entry is zero, `ctrlOut` is zero and `protoErr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| regSel | input | 3 | Register select |
| dataIn | input | 8 | Write data from host |
| dataOut | output | 8 | Read data to host |
| dataOe | output | 1 | Read data enable for the bus driver |
| ctrlOut | output | 8 | Command register contents |
| protoErr | output | 1 | Strobe collision flag |

## Verification
A register write takes effect at the clock edge where the write strobe is first seen high again. The bench therefore updates its model while it raises the strobe and compares one nanosecond after the next rising edge. Read data and `dataOe` are due one edge after the read strobe is seen low. The bench samples them at the following falling edge, after it has already moved `regSel` away, which shows that the select was captured at the start of the access. Address stepping and the preload of the next entry finish at the edge that sees the read strobe high, so the model advances at that point. `protoErr` and `ctrlOut` are compared against the model every cycle.

// File: rtl/palHostPkg.sv
package palHostPkg;

  typedef enum logic [2:0] {
    SEL_WADDR  = 3'd0,
    SEL_PAL    = 3'd1,
    SEL_MASK   = 3'd2,
    SEL_RADDR  = 3'd3,
    SEL_OWADDR = 3'd4,
    SEL_OVL    = 3'd5,
    SEL_CMD    = 3'd6,
    SEL_ORADDR = 3'd7
  } selE;

  // strobes from control to datapath
  typedef struct packed {
    logic wrStb;   // write completes this cycle
    logic rdEnd;   // read completes this cycle
    logic rdOn;    // read in progress, drive bus
    selE  sel;     // captured select of the access
  } hostStbT;

endpackage

// File: rtl/palHostCtrl.sv
module palHostCtrl
  import palHostPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic [2:0] regSel,
  output hostStbT    stb,
  output logic       protoErr
);

  logic rdQ, wrQ, abortQ;
  selE  selW, selR;
  logic bothLow, bothHigh;

  assign bothLow  = !rdN && !wrN;
  assign bothHigh = rdN && wrN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ    <= 1'b1;
      wrQ    <= 1'b1;
      abortQ <= 1'b0;
      selW   <= SEL_WADDR;
      selR   <= SEL_WADDR;
    end else begin
      rdQ    <= rdN;
      wrQ    <= wrN;
      abortQ <= bothLow || (abortQ && !bothHigh);
      if (wrQ && !wrN) selW <= selE'(regSel);
      if (rdQ && !rdN) selR <= selE'(regSel);
    end
  end

  always_comb begin
    stb.wrStb = !wrQ && wrN && rdN && !abortQ;
    stb.rdEnd = !rdQ && rdN && wrN && !abortQ;
    stb.rdOn  = !rdQ && wrN && !abortQ;
    stb.sel   = stb.wrStb ? selW : selR;
  end

  assign protoErr = abortQ;

  // R1: a completed write must follow a cycle with the strobe low
  a_r1_write_follows_low: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb |-> $past(!wrN));

  // R7: the flag may not drop while a strobe is still low
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (protoErr && !rdN) |=> protoErr);

  // R7, R9: a collision never leaves the bus driven
  a_r7_no_drive_on_collision: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !wrN) |=> !stb.rdOn);

endmodule

// File: rtl/palHostDp.sv
module palHostDp
  import palHostPkg::*;
#(
  parameter int DW        = 8,
  parameter int PAL_DEPTH = 256,
  parameter int OVL_DEPTH = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  hostStbT       stb,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut,
  output logic          dataOe,
  output logic [DW-1:0] ctrlOut
);

  localparam int AW = $clog2(PAL_DEPTH);
  localparam int OW = $clog2(OVL_DEPTH);
  localparam int EW = 3 * DW;

  logic [EW-1:0]        palMem [PAL_DEPTH];
  logic [EW-1:0]        ovlMem [OVL_DEPTH];
  logic [AW-1:0]        addr, addrNext, dinAddr;
  logic [1:0]           cnt;
  logic [2:0][DW-1:0]   hold;   // [2]=red [1]=green [0]=blue
  logic [DW-1:0]        mask, cmd;
  logic                 isData, isOvl;
  logic [EW-1:0]        nextEnt;

  function automatic logic [EW-1:0] ovlRd(input logic [OW-1:0] idx);
    return (idx == '0) ? '0 : ovlMem[idx];
  endfunction

  assign addrNext = addr + AW'(1);
  assign dinAddr  = AW'(dataIn);
  assign isOvl    = (stb.sel == SEL_OVL);
  assign isData   = (stb.sel == SEL_PAL) || isOvl;
  assign nextEnt  = isOvl ? ovlRd(addrNext[OW-1:0]) : palMem[addrNext];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAL_DEPTH; i++) palMem[i] <= '0;
      for (int i = 0; i < OVL_DEPTH; i++) ovlMem[i] <= '0;
      addr <= '0;
      cnt  <= '0;
      hold <= '0;
      mask <= '0;
      cmd  <= '0;
    end else if (stb.wrStb) begin
      case (stb.sel)
        SEL_WADDR, SEL_OWADDR: begin
          addr <= dinAddr;
          cnt  <= '0;
        end
        SEL_RADDR: begin
          addr <= dinAddr;
          cnt  <= '0;
          hold <= palMem[dinAddr];
        end
        SEL_ORADDR: begin
          addr <= dinAddr;
          cnt  <= '0;
          hold <= ovlRd(dataIn[OW-1:0]);
        end
        SEL_MASK: mask <= dataIn;
        SEL_CMD:  cmd  <= dataIn;
        default: begin  // palette or overlay data
          if (cnt == 2'd2) begin
            hold[0] <= dataIn;
            if (!isOvl) palMem[addr] <= {hold[2], hold[1], dataIn};
            else if (addr[OW-1:0] != '0) ovlMem[addr[OW-1:0]] <= {hold[2], hold[1], dataIn};
            addr <= addrNext;
            cnt  <= '0;
          end else begin
            hold[2'd2 - cnt] <= dataIn;
            cnt <= cnt + 2'd1;
          end
        end
      endcase
    end else if (stb.rdEnd && isData) begin
      if (cnt == 2'd2) begin
        addr <= addrNext;
        cnt  <= '0;
        hold <= nextEnt;
      end else begin
        cnt <= cnt + 2'd1;
      end
    end
  end

  logic [DW-1:0] rdMux;
  always_comb begin
    case (stb.sel)
      SEL_PAL, SEL_OVL: rdMux = hold[2'd2 - cnt];
      SEL_MASK:         rdMux = mask;
      SEL_CMD:          rdMux = cmd;
      default:          rdMux = DW'(addr);
    endcase
  end

  assign dataOe  = stb.rdOn;
  assign dataOut = stb.rdOn ? rdMux : '0;
  assign ctrlOut = cmd;

  // R4: byte counter never reaches an unused state
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt != 2'd3);

  // R4: completing a blue write advances the address by one
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && isData && cnt == 2'd2) |=> addr == $past(addrNext));

  // R2: control pins move only on a command write
  a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrStb && stb.sel == SEL_CMD) |=> $stable(ctrlOut));

  // R6: overlay slot 0 never holds data
  a_r6_slot0_empty: assert property (@(posedge clk) disable iff (!rstN)
    ovlMem[0] == '0);

endmodule

// File: rtl/palHostPort.sv
module palHostPort
  import palHostPkg::*;
#(
  parameter int DW        = 8,
  parameter int PAL_DEPTH = 256,
  parameter int OVL_DEPTH = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdN,
  input  logic          wrN,
  input  logic [2:0]    regSel,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut,
  output logic          dataOe,
  output logic [DW-1:0] ctrlOut,
  output logic          protoErr
);

  hostStbT stb;

  palHostCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdN      (rdN),
    .wrN      (wrN),
    .regSel   (regSel),
    .stb      (stb),
    .protoErr (protoErr)
  );

  palHostDp #(
    .DW        (DW),
    .PAL_DEPTH (PAL_DEPTH),
    .OVL_DEPTH (OVL_DEPTH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe),
    .ctrlOut (ctrlOut)
  );

endmodule

// File: tb/test_palHostPort.sv
`timescale 1ns/1ps
module test_palHostPort;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdN = 1'b1;
  logic       wrN = 1'b1;
  logic [2:0] regSel = 3'd0;
  logic [7:0] dataIn = 8'd0;
  logic [7:0] dataOut, ctrlOut;
  logic       dataOe, protoErr;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  palHostPort i_palHostPort (
    .clk(clk), .rstN(rstN), .rdN(rdN), .wrN(wrN), .regSel(regSel),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .ctrlOut(ctrlOut), .protoErr(protoErr)
  );

  // behavioural model
  logic [23:0] mPal [256];
  logic [23:0] mOvl [16];
  int          mAddr, mCnt;
  logic [23:0] mHold;
  logic [7:0]  mMask, mCmd;
  bit          expErr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] ovlEnt(input int idx);
    return (idx % 16 == 0) ? 24'd0 : mOvl[idx % 16];
  endfunction

  function automatic logic [7:0] expRead(input int s);
    case (s)
      1, 5:    return mHold[23 - 8*mCnt -: 8];
      2:       return mMask;
      6:       return mCmd;
      default: return mAddr[7:0];
    endcase
  endfunction

  task automatic modelWrite(input int s, input logic [7:0] d);
    case (s)
      0, 4: begin mAddr = d; mCnt = 0; end
      3:    begin mAddr = d; mCnt = 0; mHold = mPal[d]; end
      7:    begin mAddr = d; mCnt = 0; mHold = ovlEnt(d); end
      2:    mMask = d;
      6:    mCmd = d;
      default: begin
        mHold[23 - 8*mCnt -: 8] = d;
        if (mCnt == 2) begin
          if (s == 1) mPal[mAddr] = mHold;
          else if (mAddr % 16 != 0) mOvl[mAddr % 16] = mHold;
          mAddr = (mAddr + 1) % 256;
          mCnt = 0;
        end else mCnt++;
      end
    endcase
  endtask

  task automatic modelRead(input int s);
    if (s == 1 || s == 5) begin
      if (mCnt == 2) begin
        mAddr = (mAddr + 1) % 256;
        mCnt = 0;
        mHold = (s == 1) ? mPal[mAddr] : ovlEnt(mAddr);
      end else mCnt++;
    end
  endtask

  // R1: select moved away after fall, data moved away after rise
  task automatic wr(input int s, input logic [7:0] d);
    @(negedge clk); regSel = 3'(s); dataIn = ~d; wrN = 1'b0;
    @(negedge clk); regSel = ~3'(s); dataIn = d; wrN = 1'b1;
    modelWrite(s, d);
    @(negedge clk); dataIn = ~d;
  endtask

  task automatic rd(input int s, input string req);
    logic [7:0] e;
    e = expRead(s);
    @(negedge clk); regSel = 3'(s); rdN = 1'b0;
    @(negedge clk); regSel = ~3'(s);
    chk(req, dataOut, e);
    chk("R9 oe during read", dataOe, 1'b1);
    rdN = 1'b1;
    modelRead(s);
    @(negedge clk);
    chk("R9 oe after read", dataOe, 1'b0);
    chk("R9 bus idle zero", dataOut, 8'd0);
  endtask

  // every-cycle comparison of error flag and control pins
  always @(posedge clk) begin
    if (!rstN) expErr = 1'b0;
    else expErr = (!rdN && !wrN) || (expErr && !(rdN && wrN));
    #1;
    if (rstN) begin
      chk("R7 protoErr", protoErr, expErr);
      chk("R2 ctrlOut", ctrlOut, mCmd);
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mPal[i] = '0;
    for (int i = 0; i < 16; i++) mOvl[i] = '0;
    mAddr = 0; mCnt = 0; mHold = '0; mMask = '0; mCmd = '0; expErr = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ctrlOut reset", ctrlOut, 8'd0);
    chk("R10 protoErr reset", protoErr, 1'b0);
    chk("R10 oe reset", dataOe, 1'b0);
    rd(2, "R10 mask reset");
    rd(0, "R10 addr reset");

    // R2, R3
    wr(6, 8'hA5);
    wr(2, 8'h3C);
    rd(2, "R3 mask readback");
    rd(6, "R2 cmd readback");

    // R4 palette writes with auto-increment, R8 address readback
    wr(0, 8'd5);
    wr(1, 8'h11); wr(1, 8'h22); wr(1, 8'h33);
    wr(1, 8'h44); wr(1, 8'h55); wr(1, 8'h66);
    rd(0, "R8 addr after two entries");
    // R5 read back through preload
    wr(3, 8'd5);
    for (int k = 0; k < 6; k++) rd(1, "R5 palette read");
    rd(3, "R8 read addr select");

    // R5 wrap 255 -> 0
    wr(0, 8'd255);
    wr(1, 8'hDE); wr(1, 8'hAD); wr(1, 8'hBE);
    rd(0, "R4 addr wraps on write");
    wr(3, 8'd255);
    for (int k = 0; k < 3; k++) rd(1, "R5 read entry 255");
    rd(0, "R5 addr wraps on read");
    rd(1, "R5 entry 0 preloaded");

    // R4 byte order reset by address write
    wr(0, 8'd10);
    wr(1, 8'h99);
    wr(0, 8'd10);
    wr(1, 8'h01); wr(1, 8'h02); wr(1, 8'h03);
    wr(3, 8'd10);
    for (int k = 0; k < 3; k++) rd(1, "R4 restart at red");

    // R6 overlay
    wr(4, 8'd3);
    wr(5, 8'h70); wr(5, 8'h71); wr(5, 8'h72);
    wr(4, 8'd0);
    wr(5, 8'hF0); wr(5, 8'hF1); wr(5, 8'hF2);
    rd(4, "R8 overlay addr stepped");
    wr(7, 8'd0);
    for (int k = 0; k < 6; k++) rd(5, "R6 slot 0 zero then slot 1");
    wr(7, 8'd3);
    for (int k = 0; k < 3; k++) rd(5, "R6 overlay slot 3");
    rd(7, "R8 overlay read addr");

    // R7 collision: write then read overlaps
    @(negedge clk); regSel = 3'd6; dataIn = 8'hFF; wrN = 1'b0;
    @(negedge clk); rdN = 1'b0;
    @(negedge clk);
    chk("R7 flag raised", protoErr, 1'b1);
    chk("R7 bus not driven", dataOe, 1'b0);
    wrN = 1'b1;
    @(negedge clk); rdN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 flag cleared", protoErr, 1'b0);
    rd(6, "R7 cmd unchanged");

    // R7 collision: read then write overlaps
    @(negedge clk); regSel = 3'd2; rdN = 1'b0;
    @(negedge clk); dataIn = 8'h00; wrN = 1'b0;
    @(negedge clk); rdN = 1'b1;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(2, "R7 mask unchanged");

    // R4, R5 random burst
    wr(0, 8'd100);
    for (int k = 0; k < 60; k++) wr(1, 8'($urandom));
    wr(3, 8'd100);
    for (int k = 0; k < 60; k++) rd(1, "R5 burst readback");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule